// File: doc/BRIEF.md
# Four-Channel Serial Controller Register File

This block is the software-visible register file for four serial protocol channels. Each channel owns a 32-byte window in a 128-byte region that starts at a parameterised base address (0x0A00 by default). A channel window holds three plain mode registers, a transmit trigger, an event register and an event mask. The block decodes the address, serves single-word reads and writes, and turns a trigger write into a one-cycle transmit-kick strobe for the protocol engine of that channel.

The protocol engines report conditions by pulsing per-channel event-set lines. Those bits stay set until software writes a one to them. Each channel drives its own interrupt line, which is high while any event bit is set together with its mask bit. Routing these lines to a system interrupt controller is left to the surrounding logic.

Read data is registered. It appears on `rdata` in the cycle after `rd_en` and holds its value until the next read.

Top module: `sercon_regfile`

## Requirements
- R1: After reset, all mode, event and mask registers read zero, and `rdata`, `tx_kick` and `irq` are all zero.
- R2: An access hits only when `addr[15:7]` equals the base address bits 15:7. The channel is `addr[6:5]`. Writes outside the region change nothing, and reads outside it return zero.
- R3: Offsets 0x00, 0x04 and 0x08 of each channel are independent 32-bit read/write mode registers.
- R4: A write to offset 0x0C with `wdata[15]`=1 raises `tx_kick[ch]` for exactly one cycle, the cycle after the write. With `wdata[15]`=0 there is no strobe. Offset 0x0C stores nothing and reads zero.
- R5: A 1 on `evt_set[ch*16+b]` sets event bit b of channel ch at the next clock edge. The bit stays set and is readable at offset 0x10 (bits 15:0, upper bits zero).
- R6: A write to offset 0x10 clears exactly the event bits written as 1 and leaves the other event bits unchanged.
- R7: When an event-set input and a software clear of the same bit occur in the same cycle, the bit ends up set.
- R8: Offset 0x14 is a 16-bit read/write mask register; bits 31:16 read zero.
- R9: `irq[ch]` is high whenever (event & mask) of that channel is nonzero. It follows a mask write, an event clear or an event set in the cycle after that write or set.
- R10: Reads of any other offset in a window (including unaligned ones such as 0x02 or 0x18) return zero. Writes to those offsets change no register.
- R11: `rdata` is loaded only on a cycle with `rd_en` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one access |
| rd_en | input | 1 | Read strobe for one access |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Write data |
| evt_set | input | 64 | Per-channel event-set lines, 16 per channel, channel 0 in the low bits |
| rdata | output | 32 | Registered read data |
| tx_kick | output | 4 | One-cycle transmit-start strobe per channel |
| irq | output | 4 | Interrupt request per channel |

## Verification
Every result of this block is due exactly one clock edge after its cause:
- read data is due one edge after the cycle in which `rd_en` is sampled;
- the kick strobe is due one edge after the trigger write and is gone one edge later;
- event bits and interrupt lines change one edge after a set pulse, a clear or a mask write.

Stimulus is driven on falling edges. A scoreboard queue receives the expected read word when a read is issued. The monitor compares it on the next falling edge, by which time the rising edge that loads `rdata` has passed. Kick and interrupt checks are taken on the falling edge right after the rising edge that should change them, and the kick is checked again one cycle later to confirm its single-cycle width.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

  localparam int OFS_W    = 5;
  localparam int KICK_BIT = 15;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MLO,
    SEL_MHI,
    SEL_PROT,
    SEL_KICK,
    SEL_EVT,
    SEL_MASK
  } reg_sel_e;

  // Exact-match decode of the in-window byte offset; anything else is unmapped.
  function automatic reg_sel_e reg_decode(input logic [OFS_W-1:0] ofs);
    case (ofs)
      5'h00:   return SEL_MLO;
      5'h04:   return SEL_MHI;
      5'h08:   return SEL_PROT;
      5'h0C:   return SEL_KICK;
      5'h10:   return SEL_EVT;
      5'h14:   return SEL_MASK;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sercon_decode.sv
module sercon_decode
  import sercon_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 32'h0A00,
  parameter int NCH       = 4
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic                     hit,
  output logic [$clog2(NCH)-1:0]   ch,
  output reg_sel_e                 sel
);

  localparam int CH_W  = $clog2(NCH);
  localparam int WIN_W = CH_W + OFS_W;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  always_comb begin
    hit = (addr[ADDR_W-1:WIN_W] == BASE_V[ADDR_W-1:WIN_W]);
    ch  = addr[WIN_W-1:OFS_W];
    sel = reg_decode(addr[OFS_W-1:0]);
  end

endmodule

// File: rtl/sercon_chan.sv
module sercon_chan
  import sercon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt_set,
  output logic [DATA_W-1:0] mode_lo,
  output logic [DATA_W-1:0] mode_hi,
  output logic [DATA_W-1:0] prot,
  output logic [EVT_W-1:0]  evt,
  output logic [EVT_W-1:0]  mask,
  output logic              kick,
  output logic              irq
);

  logic             mlo_en, mhi_en, prot_en, mask_en, evt_en;
  logic [EVT_W-1:0] evt_clr, evt_d;
  logic             kick_d;

  // Next-state logic
  always_comb begin
    mlo_en  = wr_stb && (sel == SEL_MLO);
    mhi_en  = wr_stb && (sel == SEL_MHI);
    prot_en = wr_stb && (sel == SEL_PROT);
    mask_en = wr_stb && (sel == SEL_MASK);
    evt_clr = (wr_stb && (sel == SEL_EVT)) ? wdata[EVT_W-1:0] : '0;
    // Hardware set is applied after the clear, so it wins on the same bit.
    evt_d   = (evt & ~evt_clr) | evt_set;
    evt_en  = (|evt_clr) || (|evt_set);
    kick_d  = wr_stb && (sel == SEL_KICK) && wdata[KICK_BIT];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo <= '0;
      mode_hi <= '0;
      prot    <= '0;
      mask    <= '0;
      evt     <= '0;
      kick    <= 1'b0;
    end else begin
      if (mlo_en)  mode_lo <= wdata;
      if (mhi_en)  mode_hi <= wdata;
      if (prot_en) prot    <= wdata;
      if (mask_en) mask    <= wdata[EVT_W-1:0];
      if (evt_en)  evt     <= evt_d;
      kick <= kick_d;
    end
  end

  assign irq = |(evt & mask);

endmodule

// File: rtl/sercon_rdmux.sv
module sercon_rdmux
  import sercon_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 16
) (
  input  logic                           hit,
  input  logic [$clog2(NCH)-1:0]         ch,
  input  reg_sel_e                       sel,
  input  logic [NCH-1:0][DATA_W-1:0]     mode_lo,
  input  logic [NCH-1:0][DATA_W-1:0]     mode_hi,
  input  logic [NCH-1:0][DATA_W-1:0]     prot,
  input  logic [NCH-1:0][EVT_W-1:0]      evt,
  input  logic [NCH-1:0][EVT_W-1:0]      mask,
  output logic [DATA_W-1:0]              rd_word
);

  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (sel)
        SEL_MLO:  rd_word = mode_lo[ch];
        SEL_MHI:  rd_word = mode_hi[ch];
        SEL_PROT: rd_word = prot[ch];
        SEL_EVT:  rd_word = DATA_W'(evt[ch]);
        SEL_MASK: rd_word = DATA_W'(mask[ch]);
        default:  rd_word = '0;
      endcase
    end
  end

endmodule

// File: rtl/sercon_regfile.sv
module sercon_regfile
  import sercon_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 32'h0A00,
  parameter int NCH       = 4,
  parameter int DATA_W    = 32,
  parameter int EVT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NCH*EVT_W-1:0]   evt_set,
  output logic [DATA_W-1:0]      rdata,
  output logic [NCH-1:0]         tx_kick,
  output logic [NCH-1:0]         irq
);

  localparam int CH_W = $clog2(NCH);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  logic            hit;
  logic [CH_W-1:0] ch;
  reg_sel_e        sel;

  sercon_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NCH(NCH)
  ) u_decode (
    .addr(addr), .hit(hit), .ch(ch), .sel(sel)
  );

  // Per-channel register sets
  logic [NCH-1:0][DATA_W-1:0] mode_lo_q, mode_hi_q, prot_q;
  logic [NCH-1:0][EVT_W-1:0]  evt_q, mask_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic wr_stb;
    assign wr_stb = wr_en && hit && (ch == CH_W'(c));

    sercon_chan #(
      .DATA_W(DATA_W), .EVT_W(EVT_W)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_stb  (wr_stb),
      .sel     (sel),
      .wdata   (wdata),
      .evt_set (evt_set[c*EVT_W +: EVT_W]),
      .mode_lo (mode_lo_q[c]),
      .mode_hi (mode_hi_q[c]),
      .prot    (prot_q[c]),
      .evt     (evt_q[c]),
      .mask    (mask_q[c]),
      .kick    (tx_kick[c]),
      .irq     (irq[c])
    );
  end

  // Read path
  logic [DATA_W-1:0] rd_word;

  sercon_rdmux #(
    .NCH(NCH), .DATA_W(DATA_W), .EVT_W(EVT_W)
  ) u_rdmux (
    .hit(hit), .ch(ch), .sel(sel),
    .mode_lo(mode_lo_q), .mode_hi(mode_hi_q), .prot(prot_q),
    .evt(evt_q), .mask(mask_q), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata <= '0;
    else if (rd_en)  rdata <= rd_word;
  end

endmodule

// File: rtl/sercon_regfile_chk.sv
module sercon_regfile_chk #(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 32'h0A00,
  parameter int NCH       = 4,
  parameter int DATA_W    = 32,
  parameter int EVT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wdata_kick,
  input logic [NCH*EVT_W-1:0] evt_set,
  input logic [DATA_W-1:0]    rdata,
  input logic [NCH-1:0]       tx_kick,
  input logic [NCH-1:0]       irq,
  input logic [NCH*EVT_W-1:0] evt_flat
);

  localparam int CH_W  = $clog2(NCH);
  localparam int WIN_W = CH_W + 5;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic       in_win;
  logic [4:0] ofs;
  logic       mapped;

  assign in_win = (addr[ADDR_W-1:WIN_W] == BASE_V[ADDR_W-1:WIN_W]);
  assign ofs    = addr[4:0];
  assign mapped = (ofs == 5'h00) || (ofs == 5'h04) || (ofs == 5'h08) ||
                  (ofs == 5'h10) || (ofs == 5'h14);

  // R4: never more than one channel kicked at once
  a_r4_kick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_kick));

  // R4: every kick is caused by a trigger write to that channel in the previous cycle
  for (genvar c = 0; c < NCH; c++) begin : g_kick
    a_r4_kick_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kick[c] |-> $past(wr_en && in_win && (addr[WIN_W-1:5] == CH_W'(c)) &&
                           (ofs == 5'h0C) && wdata_kick));
  end

  // R5 / R7: a set input always lands, whatever the software wrote in the same cycle
  a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_flat & $past(evt_set)) == $past(evt_set)));

  // R9: a rising interrupt needs a write or an event set one cycle earlier
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != '0) |-> $past(wr_en || (evt_set != '0)));

  // R2 / R10: outside the region or at an unmapped offset, reads return zero
  a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (!in_win || !mapped)) |=> (rdata == '0));

  // R11: read data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind sercon_regfile sercon_regfile_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NCH(NCH), .DATA_W(DATA_W), .EVT_W(EVT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata_kick (wdata[15]),
  .evt_set    (evt_set),
  .rdata      (rdata),
  .tx_kick    (tx_kick),
  .irq        (irq),
  .evt_flat   (evt_q)
);

// File: tb/test_sercon_regfile.sv
module test_sercon_regfile;

  localparam int ADDR_W = 16;
  localparam int NCH    = 4;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 16;
  localparam int BASE   = 32'h0A00;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic                 rst_n = 1'b0;
  logic                 wr_en = 1'b0;
  logic                 rd_en = 1'b0;
  logic [ADDR_W-1:0]    addr  = '0;
  logic [DATA_W-1:0]    wdata = '0;
  logic [NCH*EVT_W-1:0] evt_set = '0;
  logic [DATA_W-1:0]    rdata;
  logic [NCH-1:0]       tx_kick;
  logic [NCH-1:0]       irq;

  sercon_regfile i_sercon_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .evt_set(evt_set), .rdata(rdata), .tx_kick(tx_kick), .irq(irq)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              rd_fire = 1'b0;

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] a(input int ch, input int ofs);
    return ADDR_W'(BASE + ch * 32 + ofs);
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issues a read and pushes its expected word to the scoreboard
  task automatic rd(input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] e,
                    input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ad;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_set(input int ch, input logic [EVT_W-1:0] bits);
    @(negedge clk);
    evt_set = '0;
    evt_set[ch*EVT_W +: EVT_W] = bits;
    @(negedge clk);
    evt_set = '0;
  endtask

  // Monitor: rdata is due one rising edge after rd_en was sampled
  always @(posedge clk) rd_fire <= rd_en;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected read result actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", rdata, '0);
    check("R1 tx_kick", DATA_W'(tx_kick), '0);
    check("R1 irq", DATA_W'(irq), '0);
    rd(a(0, 'h00), '0, "R1 mode_lo reset");
    rd(a(3, 'h10), '0, "R1 event reset");
    rd(a(2, 'h14), '0, "R1 mask reset");

    // R3 mode registers, distinct per channel (R2 channel select)
    for (int c = 0; c < NCH; c++) begin
      wr(a(c, 'h00), 32'h1100_0000 + c);
      wr(a(c, 'h04), 32'h2200_0000 + c);
      wr(a(c, 'h08), 32'hA5A5_0000 | c);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(a(c, 'h00), 32'h1100_0000 + c, "R3 mode_lo");
      rd(a(c, 'h04), 32'h2200_0000 + c, "R3 mode_hi");
      rd(a(c, 'h08), 32'hA5A5_0000 | c, "R3 protocol mode");
    end

    // R2 outside the region
    wr(16'h0B00, 32'hDEAD_BEEF);
    rd(16'h0B00, '0, "R2 outside read");
    rd(a(0, 'h00), 32'h1100_0000, "R2 outside write ignored");
    wr(16'h0980, 32'hCAFE_F00D);
    rd(a(0, 'h00), 32'h1100_0000, "R2 below region write ignored");

    // R10 unmapped offsets
    wr(a(1, 'h18), 32'hFFFF_FFFF);
    rd(a(1, 'h18), '0, "R10 unmapped read");
    rd(a(1, 'h14), '0, "R10 unmapped write left mask");
    rd(a(1, 'h10), '0, "R10 unmapped write left event");
    wr(a(1, 'h02), 32'h1234_5678);
    rd(a(1, 'h02), '0, "R10 unaligned read");
    rd(a(1, 'h00), 32'h1100_0001, "R10 unaligned write ignored");

    // R4 transmit kick
    wr(a(1, 'h0C), 32'h0000_8000);
    check("R4 kick raised", DATA_W'(tx_kick), 32'h2);
    @(negedge clk);
    check("R4 kick one cycle", DATA_W'(tx_kick), '0);
    wr(a(2, 'h0C), 32'h0000_7FFF);
    check("R4 no kick without bit 15", DATA_W'(tx_kick), '0);
    @(negedge clk);
    check("R4 no kick later", DATA_W'(tx_kick), '0);
    rd(a(1, 'h0C), '0, "R4 trigger stores nothing");

    // R5 event set
    pulse_set(3, 16'h00A5);
    check("R9 masked event no irq", DATA_W'(irq), '0);
    rd(a(3, 'h10), 32'h0000_00A5, "R5 event set");
    rd(a(2, 'h10), '0, "R5 other channel untouched");

    // R8 / R9 mask
    wr(a(3, 'h14), 32'hFFFF_0004);
    check("R9 irq after mask write", DATA_W'(irq), 32'h8);
    rd(a(3, 'h14), 32'h0000_0004, "R8 mask readback");

    // R6 write-one-to-clear
    wr(a(3, 'h10), 32'h0000_0004);
    check("R9 irq after clear", DATA_W'(irq), '0);
    rd(a(3, 'h10), 32'h0000_00A1, "R6 clear one bit");
    wr(a(3, 'h10), 32'h0000_0081);
    rd(a(3, 'h10), 32'h0000_0020, "R6 clear two bits");

    // R7 set beats clear in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = a(3, 'h10); wdata = 32'h0000_0060;
    evt_set = '0; evt_set[3*EVT_W +: EVT_W] = 16'h0040;
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0;
    rd(a(3, 'h10), 32'h0000_0040, "R7 set wins over clear");

    // R9 irq raised by an event set, dropped by a mask write
    pulse_set(3, 16'h0004);
    check("R9 irq after event set", DATA_W'(irq), 32'h8);
    wr(a(3, 'h14), 32'h0000_0000);
    check("R9 irq after mask cleared", DATA_W'(irq), '0);

    // R11 read data holds
    rd(a(0, 'h04), 32'h2200_0000, "R11 read");
    repeat (3) @(negedge clk);
    check("R11 rdata holds", rdata, 32'h2200_0000);

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_up();
  end

endmodule